// File: doc/BRIEF.md
# Dual Blink PWM LED Selector

This block drives sixteen open-drain LED pins from two independent blink generators. Each generator has an 8-bit period prescaler and an 8-bit duty register. A shared base tick, divided down from the system clock, steps each generator's prescaler. Every terminal count of the prescaler advances that generator's 8-bit duty counter. The generator's level is "on" while its counter is below its duty value.

Every pin has a 2-bit mode taken from four selector bytes. The mode either releases the pin, sinks it low, or makes it follow one of the two generators. The drive of each pin is registered, so it changes cleanly on one clock edge. The pin levels are synchronised and presented as two bytes, whatever mode each pin is in.

Software-side configuration arrives on a single-cycle write port: strobe, address and data. The serial bus front end and the pad drivers sit outside this block. Each pin is modelled as an enable: 1 means "drive the pin low".

Top module: `led_blink_mux`

## Requirements
- R1: After reset, all prescaler, duty and selector registers are 0x00 and every pin is released (`pin_drive_low` all zero). A later reset brings the block back to this state. With zero duty values, no pin is ever driven while it is in a blink mode.
- R2: Mode code 2'b00 releases the pin. Mode code 2'b01 drives it low.
- R3: Mode code 2'b10 makes the pin follow generator A. Mode code 2'b11 makes it follow generator B. The two generators run independently of each other.
- R4: The write addresses are: 0 = prescaler A, 1 = duty A, 2 = prescaler B, 3 = duty B, 4+k = selector byte k (k = 0..3). Selector byte k holds LEDs 4k..4k+3. LED 4k+j uses bits [2j+1:2j] of that byte.
- R5: A generator's level is on while its counter is below its duty value D. Over one full period, a follower pin is driven for D*(P+1)*TICK_DIV clocks out of 256*(P+1)*TICK_DIV clocks. So D=0 never drives the pin, and D=255 drives it for 255/256 of the period.
- R6: The duty counter advances once every P+1 base ticks, where P is the prescaler value. A base tick occurs once every TICK_DIV system clocks.
- R7: A write to a duty register restarts that generator's counter and prescaler from 0. After the write, the first on-run of a follower pin lasts D*(P+1)*TICK_DIV clocks, give or take one clock of base-tick phase.
- R8: `pin_level` equals `pin_in` as it was two clock edges earlier, in every mode. Bits 7:0 form input byte 0 (LEDs 0–7) and bits 15:8 form input byte 1 (LEDs 8–15), with the LED number equal to the bit index.
- R9: A selector write captured at clock edge E changes `pin_drive_low` at edge E+1, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_addr | input | 3 | Register address (see R4) |
| wr_data | input | 8 | Register write data |
| pin_in | input | 16 | Sampled pad levels, one per LED |
| pin_drive_low | output | 16 | 1 = sink the pin low (LED on) |
| pin_level | output | 16 | Synchronised pin levels: input byte 1 in bits 15:8, input byte 0 in bits 7:0 |

## Verification
A duty-register write and a prescaler terminal count can land on the same edge, so the restart has to win over the counter step. The bench provokes this by rewriting a duty value at a sweep of phase offsets, under several prescaler settings. It judges the result by the length of the first on-run after each write, which must match D*(P+1)*TICK_DIV within one clock. Duty accuracy is checked separately, by counting driven cycles over whole periods for a near-exhaustive sweep of duty values.

// File: rtl/led_mux_pkg.sv
// Shared constants and types for the dual blink LED selector.
// Assumes 8-bit configuration registers and two blink generators.
package led_mux_pkg;

    localparam int REG_W        = 8;
    localparam int NUM_SRC      = 2;
    localparam int MODE_W       = 2;
    localparam int LEDS_PER_SEL = REG_W / MODE_W;
    localparam int SEL_BASE     = 4;

    // Per-pin drive mode held in the selector bytes
    typedef enum logic [MODE_W-1:0] {
        MODE_RELEASE = 2'b00,
        MODE_SINK    = 2'b01,
        MODE_SRC_A   = 2'b10,
        MODE_SRC_B   = 2'b11
    } led_mode_e;

    // Address of the prescaler register of generator s
    function automatic int psc_addr(input int s);
        return 2 * s;
    endfunction

    // Address of the duty register of generator s
    function automatic int duty_addr(input int s);
        return 2 * s + 1;
    endfunction

endpackage

// File: rtl/led_tick_gen.sv
// Base tick divider: emits a one-cycle pulse every DIV system clocks.
// Assumes DIV >= 1; DIV = 1 gives a tick on every clock.
module led_tick_gen #(
    parameter int DIV = 6425
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] div_q;

    // Free-running divide counter, wraps at DIV-1
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (div_q == CW'(DIV - 1))
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == CW'(DIV - 1));
endmodule

// File: rtl/led_blink_src.sv
// One blink generator: a prescaler that divides the base tick by psc_i+1,
// and a CNT_W-bit duty counter stepped at each prescaler terminal count.
// Level is on while the counter is below duty_i. restart_i clears both
// counters; it is asserted in the same cycle as the duty register write.
module led_blink_src #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] psc_i,
    input  logic [CNT_W-1:0] duty_i,
    output logic             lvl_o
);
    logic [CNT_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic             step;

    // Terminal count also catches a prescaler lowered below the current count
    assign step = tick && (pre_q >= psc_i);

    // Prescaler: counts base ticks, restarts on terminal count or duty write
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i)
            pre_q <= '0;
        else if (step)
            pre_q <= '0;
        else if (tick)
            pre_q <= pre_q + 1'b1;
    end

    // Duty counter: one step per prescaler period, wraps naturally at 2^CNT_W
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i)
            cnt_q <= '0;
        else if (step)
            cnt_q <= cnt_q + 1'b1;
    end

    assign lvl_o = (cnt_q < duty_i);
endmodule

// File: rtl/led_pin_sync.sv
// Two-flop synchroniser for W asynchronous pin levels.
// Assumes the pins are quasi-static. The flops carry no reset, as a pure data path.
module led_pin_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    // Two stages of resynchronisation
    always_ff @(posedge clk) begin
        meta_q <= d;
        stab_q <= meta_q;
    end

    assign q = stab_q;
endmodule

// File: rtl/led_blink_mux.sv
// Top: register bank, two blink generators, per-pin 2-bit mode selector
// with a registered open-drain enable, and synchronised pin readback.
// Assumes single-cycle writes and NUM_LEDS a multiple of 8.
module led_blink_mux
    import led_mux_pkg::*;
#(
    parameter  int NUM_LEDS = 16,
    parameter  int TICK_DIV = 6425,
    localparam int NUM_SEL  = NUM_LEDS / LEDS_PER_SEL,
    localparam int ADDR_W   = $clog2(SEL_BASE + NUM_SEL)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [REG_W-1:0]    wr_data,
    input  logic [NUM_LEDS-1:0] pin_in,
    output logic [NUM_LEDS-1:0] pin_drive_low,
    output logic [NUM_LEDS-1:0] pin_level
);
    logic [NUM_SRC-1:0][REG_W-1:0] psc_q;
    logic [NUM_SRC-1:0][REG_W-1:0] duty_q;
    logic [NUM_SRC-1:0]            restart;
    logic [NUM_SRC-1:0]            src_lvl;
    logic [NUM_SEL-1:0][REG_W-1:0] sel_q;
    logic [MODE_W*NUM_LEDS-1:0]    sel_flat;
    logic [NUM_LEDS-1:0]           drive_d;
    logic [NUM_LEDS-1:0]           drive_q;
    logic                          tick;

    led_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        localparam logic [ADDR_W-1:0] PSC_A  = ADDR_W'(psc_addr(s));
        localparam logic [ADDR_W-1:0] DUTY_A = ADDR_W'(duty_addr(s));

        assign restart[s] = wr_en && (wr_addr == DUTY_A);

        // Prescaler register of generator s
        always_ff @(posedge clk) begin
            if (!rst_n)
                psc_q[s] <= '0;
            else if (wr_en && (wr_addr == PSC_A))
                psc_q[s] <= wr_data;
        end

        // Duty register of generator s (write also restarts the generator)
        always_ff @(posedge clk) begin
            if (!rst_n)
                duty_q[s] <= '0;
            else if (restart[s])
                duty_q[s] <= wr_data;
        end

        led_blink_src #(.CNT_W(REG_W)) u_src (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .restart_i(restart[s]),
            .psc_i    (psc_q[s]),
            .duty_i   (duty_q[s]),
            .lvl_o    (src_lvl[s])
        );
    end

    for (genvar k = 0; k < NUM_SEL; k++) begin : g_sel
        localparam logic [ADDR_W-1:0] SEL_A = ADDR_W'(SEL_BASE + k);

        // Selector byte k: modes of LEDs 4k..4k+3
        always_ff @(posedge clk) begin
            if (!rst_n)
                sel_q[k] <= '0;
            else if (wr_en && (wr_addr == SEL_A))
                sel_q[k] <= wr_data;
        end
    end

    assign sel_flat = sel_q;

    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_pin
        led_mode_e mode;
        assign mode = led_mode_e'(sel_flat[MODE_W*i +: MODE_W]);

        // Map the pin's mode to the sink enable
        always_comb begin
            unique case (mode)
                MODE_RELEASE: drive_d[i] = 1'b0;
                MODE_SINK:    drive_d[i] = 1'b1;
                MODE_SRC_A:   drive_d[i] = src_lvl[0];
                MODE_SRC_B:   drive_d[i] = src_lvl[1];
                default:      drive_d[i] = 1'b0;
            endcase
        end
    end

    // Registered pin enables so each pin changes on a single edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            drive_q <= '0;
        else
            drive_q <= drive_d;
    end

    assign pin_drive_low = drive_q;

    led_pin_sync #(.W(NUM_LEDS)) u_sync (
        .clk(clk),
        .d  (pin_in),
        .q  (pin_level)
    );
endmodule

// File: rtl/led_blink_mux_chk.sv
// Property checker for led_blink_mux, attached by bind below.
// Observes ports plus the selector bank and generator levels.
module led_blink_mux_chk
    import led_mux_pkg::*;
#(
    parameter int NUM_LEDS = 16,
    parameter int ADDR_W   = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic [REG_W-1:0]           wr_data,
    input logic [MODE_W*NUM_LEDS-1:0] sel_flat,
    input logic [NUM_SRC-1:0]         src_lvl,
    input logic [NUM_LEDS-1:0]        pin_in,
    input logic [NUM_LEDS-1:0]        pin_drive_low,
    input logic [NUM_LEDS-1:0]        pin_level
);
    localparam logic [ADDR_W-1:0] DUTY_A_ADDR = ADDR_W'(duty_addr(0));
    localparam logic [ADDR_W-1:0] DUTY_B_ADDR = ADDR_W'(duty_addr(1));

    logic [1:0] age_q = 2'd0;

    // Counts the first edges so that a two-deep history exists
    always_ff @(posedge clk) begin
        if (age_q != 2'd2)
            age_q <= age_q + 1'b1;
    end

    AST_RESET_DARK: assert property (@(posedge clk)
        !rst_n |=> (pin_drive_low == '0)) else $error("reset drive"); // R1

    AST_RESTART_ON_A: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == DUTY_A_ADDR && wr_data != '0) |=> src_lvl[0]) else $error("restart A"); // R7

    AST_RESTART_ON_B: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == DUTY_B_ADDR && wr_data != '0) |=> src_lvl[1]) else $error("restart B"); // R7

    AST_ZERO_DUTY_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == DUTY_A_ADDR && wr_data == '0) |=> !src_lvl[0]) else $error("zero duty"); // R5

    AST_SYNC_DELAY: assert property (@(posedge clk)
        (age_q == 2'd2) |-> (pin_level == $past(pin_in, 2))) else $error("sync delay"); // R8

    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
        AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_flat[MODE_W*i +: MODE_W] == 2'b00) |=> !pin_drive_low[i]) else $error("release"); // R2

        AST_ON_SINKS: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_flat[MODE_W*i +: MODE_W] == 2'b01) |=> pin_drive_low[i]) else $error("sink"); // R2

        AST_FOLLOW_A: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_flat[MODE_W*i +: MODE_W] == 2'b10) |=> (pin_drive_low[i] == $past(src_lvl[0]))) else $error("follow A"); // R3

        AST_FOLLOW_B: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_flat[MODE_W*i +: MODE_W] == 2'b11) |=> (pin_drive_low[i] == $past(src_lvl[1]))) else $error("follow B"); // R3
    end
endmodule

bind led_blink_mux led_blink_mux_chk #(
    .NUM_LEDS(NUM_LEDS),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .sel_flat     (sel_flat),
    .src_lvl      (src_lvl),
    .pin_in       (pin_in),
    .pin_drive_low(pin_drive_low),
    .pin_level    (pin_level)
);

// File: tb/led_blink_mux_bench.sv
module led_blink_mux_bench;
    localparam int N   = 16;
    localparam int DIV = 2;

    logic          clk     = 1'b0;
    logic          rst_n   = 1'b0;
    logic          wr_en   = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [N-1:0]  pin_in  = '0;
    logic [N-1:0]  drv;
    logic [N-1:0]  lvl;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;
    int  cnt [N];

    always #2 clk = ~clk;

    led_blink_mux #(.NUM_LEDS(N), .TICK_DIV(DIV)) u_led_blink_mux (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .pin_in       (pin_in),
        .pin_drive_low(drv),
        .pin_level    (lvl)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Write captured at the next rising edge; returns at the negedge after it
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_modes(input logic [31:0] codes);
        for (int k = 0; k < 4; k++) wr(3'(4 + k), codes[8*k +: 8]);
        @(negedge clk);
    endtask

    function automatic logic [31:0] codes_from_on(input logic [N-1:0] on);
        logic [31:0] c = '0;
        for (int i = 0; i < N; i++) c[2*i] = on[i];
        return c;
    endfunction

    task automatic count_all(input int n);
        for (int i = 0; i < N; i++) cnt[i] = 0;
        repeat (n) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) cnt[i] += int'(drv[i]);
        end
    endtask

    // First on-run of a pin measured from the cycle after a write
    task automatic run_len(input int pin, output int run);
        run = 0;
        @(negedge clk);
        while (drv[pin] && run < 70000) begin
            run++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int run;
        int exp;
        logic [N-1:0] pat;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(drv == '0, "R1 reset drive", drv, 0);
        set_modes(32'hAAAA_AAAA);
        count_all(600);
        check(cnt[0] == 0 && cnt[15] == 0, "R1 zero duty A dark", cnt[0] + cnt[15], 0);
        set_modes(32'hFFFF_FFFF);
        count_all(600);
        check(cnt[3] == 0 && cnt[12] == 0, "R1 zero duty B dark", cnt[3] + cnt[12], 0);

        // R2/R4: walking single sink, proves field position per LED
        for (int i = 0; i < N; i++) begin
            pat = N'(1) << i;
            set_modes(codes_from_on(pat));
            check(drv == pat, "R4 walking sink field", drv, pat);
        end
        set_modes(codes_from_on(16'hA5C3));
        check(drv == 16'hA5C3, "R2 mixed release/sink", drv, 16'hA5C3);
        set_modes(codes_from_on(16'hFFFF));
        check(drv == 16'hFFFF, "R2 all sink", drv, 16'hFFFF);

        // R9: drive changes one edge after the selector write
        wr(3'd4, 8'h00);
        check(drv[3:0] == 4'hF, "R9 not before next edge", drv[3:0], 4'hF);
        @(negedge clk);
        check(drv[3:0] == 4'h0, "R9 after next edge", drv[3:0], 0);

        // R8: two-edge synchronised readback, independent of mode
        for (int i = 0; i < N + 2; i++) begin
            logic [N-1:0] old;
            old = pin_in;
            pat = (i < N) ? (N'(1) << i) : ((i == N) ? 16'h3CA5 : 16'hFFFF);
            @(negedge clk);
            pin_in = pat;
            @(negedge clk);
            check(lvl == old, "R8 one edge keeps old", lvl, old);
            @(negedge clk);
            check(lvl == pat, "R8 two edges new level", lvl, pat);
        end
        pin_in = '0;

        // R5: near-exhaustive duty sweep on generator A, P=0
        wr(3'd0, 8'd0);
        set_modes(32'hAAAA_AAAA);
        for (int d = 0; d < 256; d += 3) begin
            wr(3'd1, 8'(d));
            count_all(512);
            check(cnt[0] == d * DIV, "R5 duty sweep pin0", cnt[0], d * DIV);
            check(cnt[15] == d * DIV, "R5 duty sweep pin15", cnt[15], d * DIV);
        end
        wr(3'd1, 8'd255);
        count_all(512);
        check(cnt[7] == 255 * DIV, "R5 duty 255", cnt[7], 255 * DIV);

        // R3: two independent generators, interleaved followers
        wr(3'd0, 8'd0);  wr(3'd1, 8'd64);
        wr(3'd2, 8'd1);  wr(3'd3, 8'd200);
        set_modes(32'hEEEE_EEEE);
        count_all(1024);
        for (int i = 0; i < N; i++) begin
            exp = (i % 2 == 0) ? 256 : 800;
            check(cnt[i] == exp, "R3 follow A even / B odd", cnt[i], exp);
        end
        set_modes(32'hBBBB_BBBB);
        count_all(1024);
        for (int i = 0; i < N; i += 5) begin
            exp = (i % 2 == 0) ? 800 : 256;
            check(cnt[i] == exp, "R3 follow B even / A odd", cnt[i], exp);
        end

        // R6: prescaler sets the period (duty ratio and on-run length)
        set_modes(32'hAAAA_AAAA);
        for (int p = 0; p < 6; p++) begin
            if (p == 3 || p == 4) continue;
            wr(3'd0, 8'(p));
            wr(3'd1, 8'd100);
            count_all((p + 1) * 256 * DIV);
            exp = 100 * (p + 1) * DIV;
            check(cnt[2] == exp, "R6 prescaled duty count", cnt[2], exp);
            wr(3'd1, 8'd100);
            run_len(2, run);
            check(run == exp || run == exp - 1, "R6 prescaled on-run", run, exp);
        end

        // R7: restart from mid-period at varied phases, generator B
        set_modes(32'hFFFF_FFFF);
        for (int p = 0; p < 4; p++) begin
            if (p == 2) continue;
            wr(3'd2, 8'(p));
            for (int di = 0; di < 3; di++) begin
                int d;
                d = (di == 0) ? 1 : ((di == 1) ? 37 : 128);
                for (int j = 0; j < 5; j++) begin
                    wr(3'd3, 8'(d));
                    repeat (300 + j) @(negedge clk);
                    wr(3'd3, 8'(d));
                    run_len(9, run);
                    exp = d * (p + 1) * DIV;
                    check(run == exp || run == exp - 1, "R7 restart on-run", run, exp);
                end
            end
        end

        // R1: reset mid-operation clears modes and duties
        set_modes(32'h5555_5555);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(drv == '0, "R1 mid-run reset drive", drv, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(drv == '0, "R1 modes cleared", drv, 0);
        set_modes(32'hAAAA_AAAA);
        count_all(600);
        check(cnt[5] == 0, "R1 duty cleared", cnt[5], 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule